// File: doc/BRIEF.md
# Lockable Option Word Control Register

This block is the 32-bit control and status register that fronts one nonvolatile configuration word. When reset is released it spends one cycle loading its fields from the stored word. In that same cycle it compares the stored word against the bitwise inverse of a stored companion word. If the pair disagrees, the block flags an error and treats the word as all ones.

Software can then read the register and rewrite its configurable fields through a plain word-wide write port. Writing the key value 0x33CC into the upper half locks the register. From then until the next reset, every write is discarded.

A start bit asks an external programming engine to commit the value, and `startCmd` carries that request to the engine. Only software can raise it. Hardware drops it after the engine's busy line falls.

Top module: `optWordReg`

## Requirements
- R1: After reset is released, `loadDone` stays 0 for the first clock edge. At that edge the fields are loaded: bits 31:16 into the 16-bit key field, bit 15 into the load-enable flag, bits 11:8 into the size field and bits 7:4 into the tuning field. `loadDone` is 1 from then on.
- R2: If the stored word differs from the inverse of the stored complement, the error flag (bit 0) reads 1 and every field loads as all ones.
- R3: A cycle with `rdEn` high puts the register image on `rdData` at the next edge. The image is: key field in 31:16, load-enable in 15, size in 11:8, tuning in 7:4, lock flag in 2, start in 1, error in 0. Reserved bits 14:12 and 3 always read 0.
- R4: While unlocked and after the load, a cycle with `wrEn` high copies the same bit positions of `wrData` into the fields at the edge. Bits 0, 2, 3 and 14:12 of the write data have no effect.
- R5: The lock flag sets at the same edge at which the key field takes the value 0x33CC, whether by load or by write. It stays set until the next reset.
- R6: While the lock flag is set, writes change neither the fields nor the start bit.
- R7: A write with bit 1 set, made while unlocked and with `busy` low, sets the start bit and `startCmd`. A write with bit 1 clear does not clear it.
- R8: A write with bit 1 set is ignored for the start bit while `busy` is high.
- R9: The start bit clears at the edge where `busy` is sampled low after being sampled high at the previous edge. This clearing takes priority over a simultaneous set.
- R10: The error flag ignores writes. It is re-evaluated at every reset load, so a consistent pair after a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| storedWord | input | 32 | Stored configuration word |
| storedCompl | input | 32 | Stored complement of the configuration word |
| wrEn | input | 1 | Word write enable |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read enable |
| rdData | output | 32 | Registered read data |
| busy | input | 1 | Programming engine busy |
| startCmd | output | 1 | Commit request to the engine |
| loadDone | output | 1 | Reset-time load completed |

## Verification
A corrupted field, lock or error state reaches `rdData` on the first read after the fault. So every step of the bench is followed by a full-word read, which catches a stale or wrongly masked bit within two cycles. A start bit that sets or clears on the wrong edge shows directly on `startCmd`, and the bench checks it one cycle after each busy transition. Fault cases cover load mismatches, a lock taken at load versus one taken by a write, and start requests made while the engine is busy.

// File: rtl/optw_pkg.sv
package optw_pkg;
  localparam int WORD_W   = 32;
  localparam int KEY_W    = 16;
  localparam int KEY_LSB  = 16;
  localparam int LDEN_BIT = 15;
  localparam int SIZE_W   = 4;
  localparam int SIZE_LSB = 8;
  localparam int TUNE_W   = 4;
  localparam int TUNE_LSB = 4;
  localparam int LOCK_BIT = 2;
  localparam int STRT_BIT = 1;
  localparam int ERR_BIT  = 0;

  typedef struct packed {
    logic loadStb;
    logic fieldWr;
  } optStrobe_t;
endpackage

// File: rtl/optWordData.sv
module optWordData
  import optw_pkg::*;
#(
  parameter logic [KEY_W-1:0] LOCK_KEY = 16'h33CC
) (
  input  logic              clk,
  input  logic              rstN,
  input  optStrobe_t        stb,
  input  logic [WORD_W-1:0] storedWord,
  input  logic [WORD_W-1:0] storedCompl,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              startFlag,
  output logic              locked,
  output logic [WORD_W-1:0] rdData
);
  logic [KEY_W-1:0]  keyField;
  logic              ldEn;
  logic [SIZE_W-1:0] sizeField;
  logic [TUNE_W-1:0] tuneField;
  logic              errFlag;
  logic              mismatch;
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] image;

  assign mismatch = (storedWord != ~storedCompl);
  assign srcWord  = mismatch ? '1 : storedWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyField  <= '0;
      ldEn      <= 1'b0;
      sizeField <= '0;
      tuneField <= '0;
      locked    <= 1'b0;
      errFlag   <= 1'b0;
    end else if (stb.loadStb) begin
      keyField  <= srcWord[KEY_LSB +: KEY_W];
      ldEn      <= srcWord[LDEN_BIT];
      sizeField <= srcWord[SIZE_LSB +: SIZE_W];
      tuneField <= srcWord[TUNE_LSB +: TUNE_W];
      locked    <= (srcWord[KEY_LSB +: KEY_W] == LOCK_KEY);
      errFlag   <= mismatch;
    end else if (stb.fieldWr) begin
      keyField  <= wrData[KEY_LSB +: KEY_W];
      ldEn      <= wrData[LDEN_BIT];
      sizeField <= wrData[SIZE_LSB +: SIZE_W];
      tuneField <= wrData[TUNE_LSB +: TUNE_W];
      if (wrData[KEY_LSB +: KEY_W] == LOCK_KEY) locked <= 1'b1;
    end
  end

  always_comb begin
    image = '0;
    image[KEY_LSB +: KEY_W]   = keyField;
    image[LDEN_BIT]           = ldEn;
    image[SIZE_LSB +: SIZE_W] = sizeField;
    image[TUNE_LSB +: TUNE_W] = tuneField;
    image[LOCK_BIT]           = locked;
    image[STRT_BIT]           = startFlag;
    image[ERR_BIT]            = errFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) rdData <= image;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R5
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !stb.loadStb) |=> ($stable(keyField) && $stable(ldEn) && $stable(sizeField) && $stable(tuneField))); // R6
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadStb |=> $stable(errFlag)); // R10
  AST_ERR_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStb |=> (errFlag == $past(mismatch))); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[14:12] == 3'b000) && !rdData[3]); // R3
endmodule

// File: rtl/optWordCtrl.sv
module optWordCtrl
  import optw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              busy,
  input  logic              locked,
  output optStrobe_t        stb,
  output logic              startCmd,
  output logic              loadDone
);
  logic busyQ;
  logic startSet;
  logic startClr;

  assign stb.loadStb = !loadDone;
  assign stb.fieldWr = loadDone && wrEn && !locked;
  assign startSet    = stb.fieldWr && wrData[STRT_BIT] && !busy;
  assign startClr    = busyQ && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadDone <= 1'b0;
      busyQ    <= 1'b0;
      startCmd <= 1'b0;
    end else begin
      loadDone <= 1'b1;
      busyQ    <= busy;
      if (startClr)      startCmd <= 1'b0;
      else if (startSet) startCmd <= 1'b1;
    end
  end

  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone); // R1
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!startCmd && busy) |=> !startCmd); // R8
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !busy) |=> !startCmd); // R9
  AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !startCmd) |=> !startCmd); // R6
endmodule

// File: rtl/optWordReg.sv
module optWordReg
  import optw_pkg::*;
#(
  parameter logic [15:0] LOCK_KEY = 16'h33CC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] storedWord,
  input  logic [31:0] storedCompl,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        rdEn,
  output logic [31:0] rdData,
  input  logic        busy,
  output logic        startCmd,
  output logic        loadDone
);
  optStrobe_t stb;
  logic       locked;

  optWordCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .busy(busy),
    .locked(locked), .stb(stb), .startCmd(startCmd), .loadDone(loadDone)
  );

  optWordData #(.LOCK_KEY(LOCK_KEY)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .storedWord(storedWord),
    .storedCompl(storedCompl), .wrData(wrData), .rdEn(rdEn),
    .startFlag(startCmd), .locked(locked), .rdData(rdData)
  );
endmodule

// File: tb/tb_optWordReg.sv
module tb_optWordReg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] storedWord = '0;
  logic [31:0] storedCompl = '1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        busy = 1'b0;
  logic        startCmd;
  logic        loadDone;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdFired = 1'b0;

  always #4 clk = ~clk;

  optWordReg dut (
    .clk(clk), .rstN(rstN), .storedWord(storedWord), .storedCompl(storedCompl),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .busy(busy), .startCmd(startCmd), .loadDone(loadDone)
  );

  task automatic check1(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdFired <= rdEn;

  always @(negedge clk) begin
    if (rdFired && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      testsRun++;
      if (rdData !== e) begin
        testsFailed++;
        $display("FAIL %s: actual %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic readExp(input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk) rdEn = 1'b1;
    @(negedge clk) rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrWord(input logic [31:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) begin wrEn = 1'b0; wrData = '0; end
  endtask

  task automatic doReset(input logic [31:0] w, input logic [31:0] c);
    @(negedge clk) begin rstN = 1'b0; storedWord = w; storedCompl = c; end
    @(negedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 check1("R1 loadDone low before load edge", loadDone, 1'b0);
    @(negedge clk);
    check1("R1 loadDone after load edge", loadDone, 1'b1);
  endtask

  task automatic busyPulse();
    @(negedge clk) busy = 1'b1;
    @(negedge clk) busy = 1'b0;
    @(negedge clk);
    check1("R9 start cleared after busy fall", startCmd, 1'b0);
  endtask

  initial begin
    check1("R1 reset loadDone", loadDone, 1'b0);
    check1("R7 reset startCmd", startCmd, 1'b0);
    doReset(32'h1234_F5BE, ~32'h1234_F5BE);
    readExp(32'h1234_85B0, "R1/R3 load, reserved read 0");

    wrWord(32'hABCD_7FFF);
    check1("R7 start set by write", startCmd, 1'b1);
    readExp(32'hABCD_0FF2, "R4 field write, bits 0/2/3/14:12 ignored");

    wrWord(32'h0000_0000);
    readExp(32'h0000_0002, "R7 write of 0 keeps start");

    busyPulse();
    readExp(32'h0000_0000, "R9 start cleared in image");

    @(negedge clk) busy = 1'b1;
    wrWord(32'h5555_0102);
    check1("R8 start ignored while busy", startCmd, 1'b0);
    readExp(32'h5555_0100, "R8 fields written, start not set");
    @(negedge clk) busy = 1'b0;
    @(negedge clk);

    wrWord(32'h33CC_8A52);
    check1("R5 start with lock write", startCmd, 1'b1);
    readExp(32'h33CC_8A56, "R5 lock set by key write");
    busyPulse();
    readExp(32'h33CC_8A54, "R9 start cleared, lock kept");
    wrWord(32'h0000_0002);
    check1("R6 locked start ignored", startCmd, 1'b0);
    readExp(32'h33CC_8A54, "R6 locked write ignored");

    doReset(32'h1111_2222, 32'h0000_0000);
    readExp(32'hFFFF_8FF1, "R2 mismatch loads ones and error");
    wrWord(32'h0000_0000);
    readExp(32'h0000_0001, "R10 error ignores writes, R5 lock cleared by reset");

    doReset(32'h33CC_0040, ~32'h33CC_0040);
    readExp(32'h33CC_0044, "R10 error cleared on consistent load, R5 lock at load");
    wrWord(32'h0000_00F2);
    readExp(32'h33CC_0044, "R6 write after lock at load ignored");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R3: actual %0d pending reads expected 0", expQ.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule